// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a parameterised number of sources (64 by default), latches each one into a flag bit and picks the single most urgent pending source. It drives one request line to the processor, together with that source's vector number and a 32-bit vector offset word that software has stored for it. Software reaches all state through a plain 32-bit register port. Most registers also have write-only aliases that clear, set or invert bits, so one bus write changes only the chosen bits.

Sources come in two kinds, fixed at build time by a mask parameter. A persistent (level) source keeps its flag set as long as the peripheral holds its request, so software has to remove the cause before a clear can take effect. A non-persistent (edge) source sets its flag on a request rising edge and keeps it until software clears it. A group of external pins feeds a contiguous range of sources. Each pin passes through a two-flop synchroniser and has a polarity bit that selects either the rising or the falling edge.

Each source has a 5-bit priority: a 3-bit major level in bits [4:2] and a 2-bit sub-level in bits [1:0]. A major level of 0 keeps the source from ever being signalled. The register port and the request outputs are plain control and status signals with no handshake. Read data is registered, and the outputs are refreshed every cycle.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, all flags, enables, priorities, vector offset words and polarity bits are 0, `irq_req` is 0, and the status register at 0x020 reads 0.
- R2: Flag words start at 0x040 and enable words start at 0x0C0, with consecutive words 0x10 apart. Source n sits in word n/32 at bit n%32, and a read returns the stored word.
- R3: For the control register at 0x000, the flag words, the enable words and the priority words, a write to the word address replaces the word. A write at +0x4 clears the bits written as 1, +0x8 sets them, and +0xC inverts them. A read at any of the four addresses returns the word.
- R4: Priority words start at 0x140, 0x10 apart. Source n uses word n/4 and holds its 5-bit field at bit (n%4)*8, with the major level in field bits [4:2] and the sub-level in [1:0]. All other bits of a priority word read as 0.
- R5: An edge source sets its flag on the clock edge where its request is first seen high after being low. The flag then stays set until software clears it, and it is not set again while the request simply stays high.
- R6: A level source's flag is set on every edge where its request is high. A software clear has no effect while the request is high and takes effect once the request is low.
- R7: `irq_req` goes to 1 one clock after some source has its flag set, its enable set and a nonzero major level. Otherwise `irq_req` goes to 0, and a source with major level 0 is never signalled.
- R8: The winner is the source with the highest major level. Ties go to the highest sub-level, and remaining ties go to the lowest source number.
- R9: `irq_vec` and status bits [7:0] give the winner's source number, registered alongside `irq_req`. They read 0 when nothing is pending.
- R10: External pin k drives source EXT_BASE+k as an edge source. Control bit k set to 1 selects the rising edge and 0 selects the falling edge. A pin change made before clock edge p1 sets the flag at edge p3 and raises `irq_req` at edge p4.
- R11: Source n's vector offset word sits at 0x540+4n and takes plain writes only. `irq_voff` gives the winner's word.
- R12: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_req | input | NUM_SRC | Peripheral request per source |
| ext_pin | input | NUM_EXT | Asynchronous external interrupt pins |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | 8 | Winning source number |
| irq_voff | output | 32 | Winning source's vector offset word |

## Verification
On every cycle the assertions check that a level flag is set while its request is high and that an edge flag neither appears without a request nor vanishes without a write. They also check that the request line follows the pending-and-enabled state one cycle later, that the vector is 0 whenever no request is signalled, and that alias writes to the control register take effect. Only the bench scenarios can show that the priority order is right (major level, then sub-level, then index), that a major level of 0 masks a source, and that register layout and byte lanes line up. The same holds for the exact synchroniser latency, for pin polarity, and for the vector offset that goes with each winner.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int PRI_W  = 5;

  localparam logic [ADDR_W-1:0] STAT_ADDR = 12'h020;
  localparam logic [ADDR_W-1:0] FLAG_BASE = 12'h040;
  localparam logic [ADDR_W-1:0] EN_BASE   = 12'h0C0;
  localparam logic [ADDR_W-1:0] PRI_BASE  = 12'h140;
  localparam logic [ADDR_W-1:0] VOFF_BASE = 12'h540;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_CLR = 2'd1,
    OP_SET = 2'd2,
    OP_INV = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] alias_apply(alias_op_e op,
                                                   logic [DATA_W-1:0] cur,
                                                   logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    case (op)
      OP_WR:   r = d;
      OP_CLR:  r = cur & ~d;
      OP_SET:  r = cur | d;
      default: r = cur ^ d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vic_ext_edge.sv
module vic_ext_edge #(
  parameter int NUM_EXT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] pin,
  input  logic [NUM_EXT-1:0] pol,
  output logic [NUM_EXT-1:0] evt
);
  logic [NUM_EXT-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_pin
    always_comb begin
      if (pol[k]) evt[k] = s2_q[k] & ~s3_q[k];
      else        evt[k] = ~s2_q[k] & s3_q[k];
    end

    // R10: one pin change yields a single-cycle event unless polarity flips
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      evt[k] |=> (!evt[k] || (pol[k] != $past(pol[k]))));
  end
endmodule

// File: rtl/vic_flag_bank.sv
module vic_flag_bank import vic_pkg::*; #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_EXT  = 8,
  parameter int EXT_BASE = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int NWORD = NUM_SRC / 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_EXT-1:0] ext_evt,
  input  logic [NWORD-1:0]   sw_we,
  input  alias_op_e          sw_op,
  input  logic [DATA_W-1:0]  sw_data,
  output logic [NUM_SRC-1:0] flag_q
);
  logic [NUM_SRC-1:0] req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= '0;
    else        req_d <= req;
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int  W      = n / 32;
    localparam int  B      = n % 32;
    localparam bit  IS_EXT = (n >= EXT_BASE) && (n < EXT_BASE + NUM_EXT);
    localparam bit  IS_LVL = LEVEL_MASK[n] && !IS_EXT;
    logic evt;
    logic swb;

    if (IS_EXT) begin : g_ext
      always_comb evt = ext_evt[n - EXT_BASE] | (req[n] & ~req_d[n]);
    end else if (IS_LVL) begin : g_lvl
      always_comb evt = req[n];
    end else begin : g_edge
      always_comb evt = req[n] & ~req_d[n];
    end

    always_comb begin
      case (sw_op)
        OP_WR:   swb = sw_data[B];
        OP_CLR:  swb = flag_q[n] & ~sw_data[B];
        OP_SET:  swb = flag_q[n] | sw_data[B];
        default: swb = flag_q[n] ^ sw_data[B];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[n] <= 1'b0;
      else        flag_q[n] <= (sw_we[W] ? swb : flag_q[n]) | evt;
    end

    // R5: a flag is kept until software writes its word
    assert_flag_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we[W] && flag_q[n]) |=> flag_q[n]);

    if (IS_LVL) begin : g_lvl_chk
      // R6: a level request forces the flag, whatever software writes
      assert_level_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req[n] |=> flag_q[n]);
    end else if (!IS_EXT) begin : g_edge_chk
      // R5: no request, no write -> flag stays clear
      assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we[W] && !req[n] && !flag_q[n]) |=> !flag_q[n]);
    end
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter import vic_pkg::*; #(
  parameter int NUM_SRC = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       flag,
  input  logic [NUM_SRC-1:0]       en,
  input  logic [NUM_SRC*PRI_W-1:0] pri,
  output logic                     irq_req,
  output logic [7:0]               irq_vec
);
  logic             found;
  logic [PRI_W-1:0] best_pri;
  logic [7:0]       best_idx;

  always_comb begin
    found    = 1'b0;
    best_pri = '0;
    best_idx = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (flag[n] && en[n] && (pri[n*PRI_W+2 +: 3] != 3'd0) &&
          (!found || (pri[n*PRI_W +: PRI_W] > best_pri))) begin
        found    = 1'b1;
        best_pri = pri[n*PRI_W +: PRI_W];
        best_idx = 8'(n);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= found;
      irq_vec <= found ? best_idx : 8'd0;
    end
  end

  // R7: nothing pending and enabled -> no request next cycle
  assert_idle_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag & en)) |=> !irq_req);
  // R7: a request always traces back to a pending, enabled source
  assert_req_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(|(flag & en)));
  // R9: vector reads 0 while idle
  assert_idle_vec_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == 8'd0));
  // R8: the winner is a real source
  assert_vec_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int'(irq_vec) < NUM_SRC));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl import vic_pkg::*; #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_EXT  = 8,
  parameter int EXT_BASE = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 64'h0000_0000_FFFF_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_EXT-1:0] ext_pin,
  output logic               irq_req,
  output logic [7:0]         irq_vec,
  output logic [DATA_W-1:0]  irq_voff
);
  localparam int NWORD = NUM_SRC / 32;
  localparam int NPRIW = NUM_SRC / 4;

  alias_op_e          op;
  logic [ADDR_W-1:0]  fl_off, en_off, pr_off, vo_off;
  logic               in_ctrl, in_stat, in_flag, in_en, in_pri, in_voff;
  logic [NUM_EXT-1:0] pol_q;
  logic [NUM_SRC-1:0] en_q, flag_q;
  logic [NUM_SRC*PRI_W-1:0] pri_q;
  logic [DATA_W-1:0]  voff_q [NUM_SRC];
  logic [NWORD-1:0]   flag_we;
  logic [NUM_EXT-1:0] ext_evt;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  ctrl_nxt;

  // ---------------- address decode ----------------
  assign op      = alias_op_e'(bus_addr[3:2]);
  assign fl_off  = bus_addr - FLAG_BASE;
  assign en_off  = bus_addr - EN_BASE;
  assign pr_off  = bus_addr - PRI_BASE;
  assign vo_off  = bus_addr - VOFF_BASE;
  assign in_ctrl = bus_addr < ADDR_W'(16);
  assign in_stat = bus_addr == STAT_ADDR;
  assign in_flag = (bus_addr >= FLAG_BASE) && (fl_off < ADDR_W'(NWORD * 16));
  assign in_en   = (bus_addr >= EN_BASE)   && (en_off < ADDR_W'(NWORD * 16));
  assign in_pri  = (bus_addr >= PRI_BASE)  && (pr_off < ADDR_W'(NPRIW * 16));
  assign in_voff = (bus_addr >= VOFF_BASE) && (vo_off < ADDR_W'(NUM_SRC * 4)) &&
                   (bus_addr[1:0] == 2'b00);

  // ---------------- control: edge polarity ----------------
  assign ctrl_nxt = alias_apply(op, DATA_W'(pol_q), bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pol_q <= '0;
    else if (bus_wr && in_ctrl)  pol_q <= ctrl_nxt[NUM_EXT-1:0];
  end

  // R3: a set-alias write to control turns on every written bit
  assert_ctrl_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_ctrl && (op == OP_SET)) |=>
      ((pol_q & $past(bus_wdata[NUM_EXT-1:0])) == $past(bus_wdata[NUM_EXT-1:0])));

  // ---------------- enable words ----------------
  for (genvar w = 0; w < NWORD; w++) begin : g_en
    logic [DATA_W-1:0] nxt;
    assign nxt = alias_apply(op, en_q[w*32 +: 32], bus_wdata);
    assign flag_we[w] = bus_wr && in_flag && (int'(fl_off[ADDR_W-1:4]) == w);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        en_q[w*32 +: 32] <= '0;
      else if (bus_wr && in_en && (int'(en_off[ADDR_W-1:4]) == w))
        en_q[w*32 +: 32] <= nxt;
    end
  end

  // ---------------- priority fields and vector offsets ----------------
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int PW   = n / 4;
    localparam int LANE = n % 4;
    logic [DATA_W-1:0] pnxt;
    assign pnxt = alias_apply(op, DATA_W'(pri_q[n*PRI_W +: PRI_W]),
                              DATA_W'(bus_wdata[LANE*8 +: PRI_W]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pri_q[n*PRI_W +: PRI_W] <= '0;
      else if (bus_wr && in_pri && (int'(pr_off[ADDR_W-1:4]) == PW))
        pri_q[n*PRI_W +: PRI_W] <= pnxt[PRI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        voff_q[n] <= '0;
      else if (bus_wr && in_voff && (int'(vo_off[ADDR_W-1:2]) == n))
        voff_q[n] <= bus_wdata;
    end
  end

  // ---------------- datapath submodules ----------------
  vic_ext_edge #(.NUM_EXT(NUM_EXT)) u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_pin),
    .pol   (pol_q),
    .evt   (ext_evt)
  );

  vic_flag_bank #(
    .NUM_SRC    (NUM_SRC),
    .NUM_EXT    (NUM_EXT),
    .EXT_BASE   (EXT_BASE),
    .LEVEL_MASK (LEVEL_MASK)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (src_req),
    .ext_evt (ext_evt),
    .sw_we   (flag_we),
    .sw_op   (op),
    .sw_data (bus_wdata),
    .flag_q  (flag_q)
  );

  vic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag    (flag_q),
    .en      (en_q),
    .pri     (pri_q),
    .irq_req (irq_req),
    .irq_vec (irq_vec)
  );

  always_comb begin
    irq_voff = '0;
    for (int n = 0; n < NUM_SRC; n++)
      if (int'(irq_vec) == n) irq_voff = voff_q[n];
  end

  // ---------------- read path ----------------
  always_comb begin
    rd_mux = '0;
    if (in_ctrl) begin
      rd_mux[NUM_EXT-1:0] = pol_q;
    end else if (in_stat) begin
      rd_mux[7:0] = irq_vec;
    end else if (in_flag) begin
      for (int w = 0; w < NWORD; w++)
        if (int'(fl_off[ADDR_W-1:4]) == w) rd_mux = flag_q[w*32 +: 32];
    end else if (in_en) begin
      for (int w = 0; w < NWORD; w++)
        if (int'(en_off[ADDR_W-1:4]) == w) rd_mux = en_q[w*32 +: 32];
    end else if (in_pri) begin
      for (int n = 0; n < NUM_SRC; n++)
        if (int'(pr_off[ADDR_W-1:4]) == n / 4)
          rd_mux[(n % 4)*8 +: PRI_W] = pri_q[n*PRI_W +: PRI_W];
    end else if (in_voff) begin
      for (int n = 0; n < NUM_SRC; n++)
        if (int'(vo_off[ADDR_W-1:2]) == n) rd_mux = voff_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R12: read data holds between reads
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_vic_ctrl.sv
`timescale 1ns/1ps
module test_vic_ctrl;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_req = '0;
  logic [7:0]  ext_pin = '0;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic [31:0] irq_voff;

  int n_chk = 0;
  int n_bad = 0;

  always #(HALF) clk = ~clk;

  vic_ctrl i_vic_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_req(src_req), .ext_pin(ext_pin), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_voff(irq_voff)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src_req[n] = 1'b1;
    @(negedge clk); src_req[n] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq_req", 32'(irq_req), 0);
    rd(12'h020, d); check("R1 status", d, 0);
    rd(12'h040, d); check("R1 flag word0", d, 0);
    rd(12'h140, d); check("R1 pri word0", d, 0);
    rd(12'h000, d); check("R1 polarity", d, 0);
  endtask

  task automatic t_aliases;
    logic [31:0] d;
    wr(12'h0D0, 32'hA5A5_0000); rd(12'h0D0, d); check("R2 enable word1", d, 32'hA5A5_0000);
    wr(12'h0D4, 32'hA000_0000); rd(12'h0D0, d); check("R3 clear alias", d, 32'h05A5_0000);
    wr(12'h0D8, 32'h0000_0001); rd(12'h0D0, d); check("R3 set alias", d, 32'h05A5_0001);
    wr(12'h0DC, 32'h0000_000F); rd(12'h0D4, d); check("R3 invert alias", d, 32'h05A5_000E);
    wr(12'h0D0, 32'h0);
  endtask

  task automatic t_pri_lanes;
    logic [31:0] d;
    wr(12'h150, 32'hFFFF_FFFF); rd(12'h150, d); check("R4 lanes", d, 32'h1F1F_1F1F);
    wr(12'h154, 32'h0000_FF00); rd(12'h158, d); check("R4 clear lane1", d, 32'h1F1F_001F);
    wr(12'h150, 32'h0);
  endtask

  task automatic t_edge_src;
    logic [31:0] d;
    wr(12'h1E0, 32'h0000_000D);
    wr(12'h0D8, 32'h0000_0100);
    wr(12'h5E0, 32'h0000_4000);
    pulse(40);
    @(negedge clk);
    check("R7 req after edge", 32'(irq_req), 1);
    check("R9 vec", 32'(irq_vec), 40);
    check("R11 voff", irq_voff, 32'h0000_4000);
    repeat (3) @(negedge clk);
    rd(12'h050, d); check("R5 flag held", d, 32'h0000_0100);
    rd(12'h020, d); check("R9 status", d, 40);
    wr(12'h054, 32'h0000_0100);
    @(negedge clk);
    check("R5 cleared", 32'(irq_req), 0);
  endtask

  task automatic t_level_src;
    logic [31:0] d;
    wr(12'h190, 32'h0000_0008);
    wr(12'h0C8, 32'h0010_0000);
    @(negedge clk); src_req[20] = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 level vec", 32'(irq_vec), 20);
    wr(12'h044, 32'h0010_0000);
    rd(12'h040, d); check("R6 clear ignored", d & 32'h0010_0000, 32'h0010_0000);
    check("R6 still signalled", 32'(irq_req), 1);
    @(negedge clk); src_req[20] = 1'b0;
    wr(12'h044, 32'h0010_0000);
    rd(12'h040, d); check("R6 clear after drop", d, 0);
    check("R6 idle", 32'(irq_req), 0);
  endtask

  task automatic t_major_zero;
    logic [31:0] d;
    wr(12'h1E0, 32'h0000_030D);
    wr(12'h0D8, 32'h0000_0200);
    pulse(41);
    repeat (2) @(negedge clk);
    rd(12'h050, d); check("R7 flag set", d, 32'h0000_0200);
    check("R7 major zero masked", 32'(irq_req), 0);
    rd(12'h020, d); check("R9 status idle", d, 0);
    wr(12'h054, 32'h0000_0200);
  endtask

  task automatic t_arbitrate;
    wr(12'h200, 32'h0E0C_0000);
    wr(12'h210, 32'h0000_000E);
    wr(12'h608, 32'h0000_0050);
    wr(12'h60C, 32'h0000_0051);
    wr(12'h610, 32'h0000_0052);
    wr(12'h0D8, 32'h001C_0000);
    @(negedge clk); src_req[52:50] = 3'b111;
    @(negedge clk); src_req[52:50] = 3'b000;
    @(negedge clk);
    check("R8 sub then index", 32'(irq_vec), 51);
    check("R11 voff 51", irq_voff, 32'h51);
    wr(12'h210, 32'h0000_0010);
    @(negedge clk);
    check("R8 major wins", 32'(irq_vec), 52);
    check("R11 voff 52", irq_voff, 32'h52);
    wr(12'h054, 32'h0010_0000);
    @(negedge clk);
    check("R8 next after clear", 32'(irq_vec), 51);
    wr(12'h054, 32'h0008_0000);
    @(negedge clk);
    check("R8 sub-level lowest", 32'(irq_vec), 50);
    wr(12'h054, 32'h0004_0000);
    @(negedge clk);
    check("R7 all cleared", 32'(irq_req), 0);
  endtask

  task automatic t_ext;
    logic [31:0] d;
    wr(12'h160, 32'h0004_0000);
    wr(12'h0C8, 32'h0000_0400);
    @(negedge clk); ext_pin[2] = 1'b1;
    repeat (6) @(negedge clk);
    rd(12'h040, d); check("R10 rising ignored at falling polarity", d, 0);
    @(negedge clk); ext_pin[2] = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 falling edge", 32'(irq_vec), 10);
    wr(12'h044, 32'h0000_0400);
    wr(12'h008, 32'h0000_0004);
    rd(12'h000, d); check("R3 control set alias", d, 32'h4);
    @(negedge clk); check("R10 idle before pin", 32'(irq_req), 0);
    ext_pin[2] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 not yet at p3", 32'(irq_req), 0);
    @(negedge clk);
    check("R10 request at p4", 32'(irq_req), 1);
    check("R10 vec", 32'(irq_vec), 10);
    wr(12'h044, 32'h0000_0400);
  endtask

  task automatic t_rdata_hold;
    logic [31:0] d;
    rd(12'h190, d);
    repeat (3) @(negedge clk);
    check("R12 rdata held", bus_rdata, 32'h0000_0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aliases();
    t_pri_lanes();
    t_edge_src();
    t_level_src();
    t_major_zero();
    t_arbitrate();
    t_ext();
    t_rdata_hold();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule